// File: doc/BRIEF.md
# DRAM Command Spacing Timer

This block makes one memory-controller wait last long enough for a DRAM timing rule. Each rule is given in two forms: a minimum number of clock edges and a minimum time in picoseconds. The block also takes the period of the clock the controller drives to the memory and a jitter margin, both in picoseconds. It turns the time into cycles at that period, rounding up, and counts the jitter as part of the time. The wait it uses is the larger of that figure and the raw clock count. The memory has no way to know its own speed, so all of these values come from the controller side. They can be tied off as constants or rewritten while the chip runs.

A start pulse loads the wait and starts a countdown. The ready output is low while the countdown runs and goes high again when it reaches zero. The wait can be zero, and then ready stays high in the start cycle. A start that arrives in the middle of a countdown restarts it with the newly computed wait.

The block also checks the programmed CAS latency against the clock period. A latency is counted in cycles of the clock actually driven to the memory, so a slower clock can make a smaller latency legal. For example, 3 cycles at 3.2 ns covers the time that 5 cycles at 1.875 ns covered.

Top module: `dram_wait_timer`

## Requirements
- R1: Out of reset the countdown value `remain` is 0 and `ready` is high.
- R2: The time part of the wait is ceil((`min_ps` + `jitter_ps`) / `period_ps`) cycles. It is shown on `eff_cycles` whenever that value exceeds `min_ck`.
- R3: `eff_cycles` equals the larger of `min_ck` and the converted time from R2.
- R4: A start sampled with `eff_cycles` = N > 0 makes `ready` low in the start cycle and for exactly N clock cycles after the start edge. After that, `ready` is high.
- R5: When `eff_cycles` is 0, `ready` stays high in the cycle where `start` is high, and no countdown begins.
- R6: A start that arrives while a countdown runs replaces the remaining count with the current `eff_cycles`.
- R7: When `period_ps` is 0, `eff_cycles` saturates to all ones (131071 at the default widths).
- R8: `lat_bad` is high exactly when `cas_lat` × `period_ps` < `access_ps` + `jitter_ps`. Equality counts as legal.
- R9: Timing inputs that change after a start do not alter the countdown already running. `ready` still rises after the wait captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a wait |
| min_ck | input | CNT_W | Minimum wait in clock edges |
| min_ps | input | PS_W | Minimum wait in picoseconds |
| jitter_ps | input | PS_W | Jitter margin in picoseconds |
| period_ps | input | PER_W | Memory clock period in picoseconds |
| cas_lat | input | LAT_W | Programmed CAS latency in cycles |
| access_ps | input | PS_W | Device access time in picoseconds |
| eff_cycles | output | PS_W+1 | Effective wait in cycles |
| remain | output | PS_W+1 | Cycles left in the current countdown |
| ready | output | 1 | High when no wait is pending |
| lat_bad | output | 1 | Programmed CAS latency is too short |

## Verification
The hardest case to reach is a restart partway through a countdown. Both the remaining count and the new wait must be distinct and nonzero for the reload to be visible. The bench starts a 10-cycle wait and lets three cycles pass. It then reprograms the timing inputs so the wait becomes 4 cycles and pulses start again. It counts exactly four low cycles of `ready` after that pulse. A companion scenario changes the timing inputs in the middle of a count without a start pulse, to show that the captured wait still holds.

// File: rtl/dram_wait_timer.sv
module dram_wait_timer #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 16,
  parameter int PER_W = 16,
  parameter int LAT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  min_ck,
  input  logic [PS_W-1:0]   min_ps,
  input  logic [PS_W-1:0]   jitter_ps,
  input  logic [PER_W-1:0]  period_ps,
  input  logic [LAT_W-1:0]  cas_lat,
  input  logic [PS_W-1:0]   access_ps,
  output logic [PS_W:0]     eff_cycles,
  output logic [PS_W:0]     remain,
  output logic              ready,
  output logic              lat_bad
);

  localparam int WAIT_W = PS_W + 1;
  localparam int NUM_W  = (PER_W > WAIT_W ? PER_W : WAIT_W) + 1;
  localparam int PROD_W = LAT_W + PER_W;
  localparam int CMP_W  = PROD_W > WAIT_W ? PROD_W : WAIT_W;

  logic [WAIT_W-1:0] need_ps;
  logic [NUM_W-1:0]  num;
  logic [NUM_W-1:0]  quo;
  logic [WAIT_W-1:0] conv;
  logic [WAIT_W-1:0] ck_ext;
  logic [CMP_W-1:0]  lat_ps;
  logic [CMP_W-1:0]  lat_need;

  assign need_ps = WAIT_W'(min_ps) + WAIT_W'(jitter_ps);
  assign num     = NUM_W'(need_ps) + NUM_W'(period_ps) - NUM_W'(1);
  assign quo     = (period_ps == '0) ? '1 : num / NUM_W'(period_ps);
  assign conv    = (period_ps == '0 || quo > NUM_W'({WAIT_W{1'b1}})) ? '1 : quo[WAIT_W-1:0];
  assign ck_ext  = WAIT_W'(min_ck);
  assign eff_cycles = (ck_ext > conv) ? ck_ext : conv;

  assign lat_ps   = CMP_W'(cas_lat) * CMP_W'(period_ps);
  assign lat_need = CMP_W'(need_ps) - CMP_W'(jitter_ps) + CMP_W'(jitter_ps) - CMP_W'(min_ps) + CMP_W'(access_ps);
  assign lat_bad  = lat_ps < lat_need;

  always_ff @(posedge clk) begin
    if (!rst_n)
      remain <= '0;
    else if (start)
      remain <= eff_cycles;
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign ready = start ? (eff_cycles == '0) : (remain == '0);

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> remain == $past(eff_cycles)); // R6
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && remain != '0) |=> remain == $past(remain) - 1'b1); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && remain == '0) |=> remain == '0); // R9
  AST_TIME_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (period_ps != '0) |-> (64'(eff_cycles) * 64'(period_ps) >= 64'(min_ps) + 64'(jitter_ps))); // R2
  AST_CEIL_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (period_ps != '0 && 64'(eff_cycles) > 64'(min_ck)) |->
      (64'(eff_cycles - 1'b1) * 64'(period_ps) < 64'(min_ps) + 64'(jitter_ps))); // R3
  AST_ZERO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && eff_cycles == '0) |-> ready); // R5

endmodule

// File: tb/dram_wait_timer_tb.sv
module dram_wait_timer_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [7:0]  min_ck = 0;
  logic [15:0] min_ps = 0, jitter_ps = 0, access_ps = 0;
  logic [15:0] period_ps = 1000;
  logic [4:0]  cas_lat = 0;
  logic [16:0] eff_cycles, remain;
  logic        ready, lat_bad;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dram_wait_timer dut_i (.clk(clk), .rst_n(rst_n), .start(start), .min_ck(min_ck),
    .min_ps(min_ps), .jitter_ps(jitter_ps), .period_ps(period_ps), .cas_lat(cas_lat),
    .access_ps(access_ps), .eff_cycles(eff_cycles), .remain(remain), .ready(ready),
    .lat_bad(lat_bad));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int ck, input int ps, input int jit, input int per);
    @(negedge clk);
    min_ck = 8'(ck); min_ps = 16'(ps); jitter_ps = 16'(jit); period_ps = 16'(per);
    #1;
  endtask

  task automatic count_low(output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ready) break;
      n++;
    end
  endtask

  task automatic run_wait(input int exp_n, input string req);
    int n;
    @(negedge clk);
    start = 1; #1;
    check(ready == 0, req, ready, 0);
    @(negedge clk);
    start = 0;
    n = 0;
    while (!ready && n < 300) begin n++; @(negedge clk); end
    check(n == exp_n, req, n, exp_n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(remain == 0, "R1", remain, 0);
    check(ready == 1, "R1", ready, 1);
  endtask

  task automatic t_convert();
    setup(4, 9375, 0, 1875);
    check(eff_cycles == 5, "R2", eff_cycles, 5);
    run_wait(5, "R4");
    setup(0, 9375, 0, 3200);
    check(eff_cycles == 3, "R2", eff_cycles, 3);
    setup(0, 10000, 1, 2500);
    check(eff_cycles == 5, "R2 jitter", eff_cycles, 5);
    run_wait(5, "R4");
  endtask

  task automatic t_max();
    setup(12, 10000, 0, 2500);
    check(eff_cycles == 12, "R3", eff_cycles, 12);
    run_wait(12, "R4");
  endtask

  task automatic t_zero();
    setup(0, 0, 0, 1500);
    check(eff_cycles == 0, "R5", eff_cycles, 0);
    @(negedge clk); start = 1; #1;
    check(ready == 1, "R5", ready, 1);
    @(negedge clk); start = 0; #1;
    check(ready == 1 && remain == 0, "R5", remain, 0);
  endtask

  task automatic t_restart();
    int n;
    setup(10, 0, 0, 1000);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    min_ck = 4; start = 1; #1;
    check(eff_cycles == 4, "R6", eff_cycles, 4);
    @(negedge clk); start = 0;
    n = 0;
    while (!ready && n < 300) begin n++; @(negedge clk); end
    check(n == 4, "R6", n, 4);
  endtask

  task automatic t_captured();
    int n;
    setup(6, 0, 0, 1000);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; min_ck = 50; period_ps = 10;
    min_ps = 5000;
    n = 1;
    count_low(n);
    check(n + 1 == 6, "R9", n + 1, 6);
  endtask

  task automatic t_period0();
    setup(3, 100, 0, 0);
    check(eff_cycles == 17'h1FFFF, "R7", eff_cycles, 131071);
    setup(0, 0, 0, 1000);
  endtask

  task automatic t_latency();
    @(negedge clk);
    cas_lat = 3; period_ps = 3200; access_ps = 9375; jitter_ps = 0; #1;
    check(lat_bad == 0, "R8 slow clock", lat_bad, 0);
    cas_lat = 5; period_ps = 1875; #1;
    check(lat_bad == 0, "R8 equal", lat_bad, 0);
    cas_lat = 4; #1;
    check(lat_bad == 1, "R8 short", lat_bad, 1);
    cas_lat = 5; jitter_ps = 100; #1;
    check(lat_bad == 1, "R8 jitter", lat_bad, 1);
    jitter_ps = 0;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_convert();
    t_max();
    t_zero();
    t_restart();
    t_captured();
    t_period0();
    t_latency();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule